// File: doc/BRIEF.md
# Combinational Integer Square Root Array

This block extracts the integer square root of an unsigned radicand in a single combinational pass. It has no clock. The default radicand is 8 bits wide, which gives a 4-bit root and a 5-bit remainder. The logic is a triangle of conditional-subtract cells. There is one row per root bit, and the rows run from the most significant root bit to the least significant.

Each row subtracts a trial term from a window of the partial remainder. The trial term is the root found so far with the two bits `01` appended, and the window is aligned to the current bit pair. The subtraction is done by adding the inverted trial term with a carry-in of one. A final carry of one means the difference is not negative, so that row's root bit is one.

The root bit is then fed back to every cell in its row. Each cell's sum is gated by that bit. When the bit is zero, the cell passes its original remainder bit on unchanged. This makes the array a restoring square root that needs no separate multiplexers.

The block is used wherever a root and its remainder are needed within the same cycle, with the outputs registered by the surrounding logic. The default configuration uses 17 cells, in rows of 2, 4, 5 and 6.

Top module: `cs_sqrt`

## Requirements
- R1: `root` equals the largest integer whose square does not exceed `radicand`, for every one of the 256 radicand values.
- R2: `rem` equals `radicand` minus the square of `root`, as an unsigned 5-bit value.
- R3: The square of `root` plus `rem` equals `radicand` for every input.
- R4: The square of (`root` + 1) is strictly greater than `radicand`.
- R5: `rem` never exceeds twice `root`.
- R6: At the extremes, radicand 0 gives root 0 and remainder 0, and radicand 255 gives root 15 and remainder 30.
- R7: Every perfect square from 0 to 225 gives a remainder of 0.
- R8: The outputs follow a change of `radicand` with no clock edge: they are valid one time unit after the input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| radicand | input | W (8) | Unsigned value whose square root is taken |
| root | output | W/2 (4) | Integer square root |
| rem | output | W/2+1 (5) | Radicand minus the root squared |

## Verification
A wrong root bit in an upper row does not stay in that row. It also corrupts the trial term of every row below it, and it decides whether that row's remainder window is restored. So a fault near the top shows up at both `root` and `rem` within the same evaluation, before any clock edge. A gating fault in a single cell is harder to see. It only corrupts a remainder bit when that row's root bit is zero, so it can hide behind many radicands. For that reason every radicand value is applied, and the remainder is compared as well as the root, together with the bound on the remainder.

// File: rtl/cs_sqrt.sv
module cs_sqrt #(
  parameter int W = 8,
  localparam int N = W / 2
) (
  input  logic [W-1:0] radicand,
  output logic [N-1:0] root,
  output logic [N:0]   rem
);

  logic [W-1:0] part [0:N];
  logic [N-1:0] qacc [0:N];

  assign part[0] = radicand;
  assign qacc[0] = '0;

  for (genvar k = 0; k < N; k++) begin : g_row
    localparam int J  = N - 1 - k;
    localparam int WD = (k == 0) ? 2 : k + 3;
    localparam int LO = 2 * J;

    logic [N+1:0]  trial;
    logic [WD-1:0] rwin, dinv, xsum, sout;
    logic          qbit;
    logic [W-1:0]  nxt;

    assign trial = {qacc[k], 2'b01};
    assign dinv  = ~trial[WD-1:0];
    assign rwin  = part[k][LO +: WD];

    always_comb begin
      logic c;
      c = 1'b1;
      for (int i = 0; i < WD; i++) begin
        xsum[i] = dinv[i] ^ c;
        c = (rwin[i] & dinv[i]) | (rwin[i] & c) | (dinv[i] & c);
      end
      qbit = c;
    end

    assign sout = rwin ^ (xsum & {WD{qbit}});

    always_comb begin
      nxt = part[k];
      nxt[LO +: WD] = sout;
    end

    assign part[k+1] = nxt;
    assign qacc[k+1] = {qacc[k][N-2:0], qbit};
  end

  assign root = qacc[N];
  assign rem  = part[N][N:0];

endmodule

// File: rtl/cs_sqrt_chk.sv
module cs_sqrt_chk #(
  parameter int W = 8,
  localparam int N = W / 2
) (
  input logic [W-1:0] radicand,
  input logic [N-1:0] root,
  input logic [N:0]   rem
);

  always_comb begin
    AST_EXACT_SUM: assert (int'(root) * int'(root) + int'(rem) == int'(radicand)); // R3
    AST_ROOT_MAXIMAL: assert ((int'(root) + 1) * (int'(root) + 1) > int'(radicand)); // R4
    AST_REM_BOUND: assert (int'(rem) <= 2 * int'(root)); // R5
    AST_ZERO_IN: assert (radicand != '0 || (root == '0 && rem == '0)); // R6
  end

endmodule

bind cs_sqrt cs_sqrt_chk #(.W(W)) u_chk (.radicand(radicand), .root(root), .rem(rem));

// File: tb/sim_cs_sqrt.sv
module sim_cs_sqrt;
  localparam int W = 8;
  localparam int N = W / 2;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] radicand = '0;
  logic [N-1:0] root;
  logic [N:0]   rem;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int q_a[$];
  int q_r[$];
  int q_m[$];

  cs_sqrt #(.W(W)) u0 (.radicand(radicand), .root(root), .rem(rem));

  always #(TCLK / 2) clk = ~clk;

  function automatic int ref_root(int a);
    int q = 0;
    while ((q + 1) * (q + 1) <= a) q++;
    return q;
  endfunction

  function automatic string tag_of(int a, string dflt);
    int q = ref_root(a);
    if (a == 0 || a == 255) return "R6";
    if (q * q == a) return "R7";
    return dflt;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(int a);
    @(posedge clk);
    radicand <= W'(a);
    q_a.push_back(a);
    q_r.push_back(ref_root(a));
    q_m.push_back(a - ref_root(a) * ref_root(a));
  endtask

  // monitor: compares each pushed item half a cycle after it is applied
  initial begin
    forever begin
      @(negedge clk);
      if (q_a.size() > 0) begin
        int a, er, em;
        a  = q_a.pop_front();
        er = q_r.pop_front();
        em = q_m.pop_front();
        check({tag_of(a, "R1"), " root"}, int'(root), er);
        check({tag_of(a, "R2"), " rem"}, int'(rem), em);
        check("R3 root^2+rem", int'(root) * int'(root) + int'(rem), a);
        check("R4 next square above", int'((int'(root) + 1) * (int'(root) + 1) > a), 1);
        check("R5 rem bound", int'(int'(rem) <= 2 * int'(root)), 1);
      end
    end
  end

  initial begin
    #(TCLK * 190000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    check("R6 idle root", int'(root), 0);
    check("R6 idle rem", int'(rem), 0);
    for (int a = 0; a < 256; a++) drive(a);
    for (int a = 255; a >= 0; a -= 17) drive(a);
    for (int q = 15; q >= 0; q--) drive(q * q);
    for (int q = 1; q < 16; q++) drive(q * q - 1);
    drive(255);
    drive(0);
    while (q_a.size() > 0) @(negedge clk);
    @(negedge clk);
    // R8: no clock edge between the input change and the sample
    radicand = 8'd200;
    #1;
    check("R8 root no clock", int'(root), 14);
    check("R8 rem no clock", int'(rem), 4);
    radicand = 8'd63;
    #1;
    check("R8 root no clock", int'(root), 7);
    check("R8 rem no clock", int'(rem), 14);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule